// File: doc/BRIEF.md
# Euler-Angle CORDIC Frame Rotator

This block turns a three-component fixed-point vector from a body frame into North-East-Down coordinates, given roll, pitch and yaw angles. It performs three plane rotations, one after another, on a single iterative shift-add CORDIC engine. No multiplier is used anywhere: the micro-rotations, the quarter-turn range reduction and the gain correction are all shifts, adds and sign flips.

A client offers a vector and three angles together with `valid_in`. The pair is taken on a clock edge where `ready` is high. `ready` then stays low until the result appears. The result is shown on `vec_out` with a one-cycle `valid_out` pulse, and `vec_out` holds that value until the next result. `restart` abandons any work in flight and clears the block.

Top module: `euler_ned_rotator`

## Requirements
- R1: The result is A·v with A = Rz(psi)·Ry(theta)·Rx(phi), to within 6 LSB of the exactly rounded value. A rotation by a in plane (p,q) gives p' = p·cos a − q·sin a and q' = p·sin a + q·cos a. Roll uses (p,q) = (y,z), pitch uses (z,x) and yaw uses (x,y), applied in that order. Every value is signed two's complement with W=14 bits and FRAC=10 fractional bits; angles are in radians. In `vec_in` and `vec_out`, x is in bits [13:0], y in [27:14] and z in [41:28]. In `ang_in`, phi is in [13:0], theta in [27:14] and psi in [41:28].
- R2: With all three angles zero, the output equals the input vector to within 6 LSB.
- R3: When `valid_in` is low, nothing is captured: `ready` stays high and no `valid_out` follows.
- R4: `ready` goes low on the cycle after a capture and stays low until the result is presented. Any `valid_in` or data change while `ready` is low is ignored, so the result belongs to the captured sample.
- R5: `valid_out` rises exactly LAT = 3·(ITER+2)+1 = 49 cycles after the capturing edge. `ready` returns high in that same cycle, so a `valid_in` held high is captured again on the next edge.
- R6: `valid_out` is a single-cycle pulse. `vec_out` changes only when `valid_out` rises or when it is cleared.
- R7: `restart` takes priority over everything else. On the cycle after it, `ready` is 1, `valid_out` is 0 and `vec_out` is 0. The aborted work produces no `valid_out`, and a `valid_in` in the same cycle as `restart` is not captured.
- R8: A component whose true value lies outside the output range is clamped to 8191 or −8192.
- R9: Angles anywhere in [−pi, pi] are handled. Before the micro-rotations, a quarter-turn pre-rotation brings the residual angle within the CORDIC convergence bound (about 1.743 rad).
- R10: After reset, `ready` is 1, `valid_out` is 0 and `vec_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous abort and clear; overrides `valid_in` |
| valid_in | input | 1 | Offers `vec_in` and `ang_in` |
| vec_in | input | 42 | Input vector {z, y, x} |
| ang_in | input | 42 | Angles {psi, theta, phi} in radians |
| vec_out | output | 42 | Rotated vector {z, y, x} |
| valid_out | output | 1 | One-cycle pulse marking a new result |
| ready | output | 1 | Block is idle and will take a valid input |

## Verification
The hardest case to reach from the ports is an angle near ±pi. There the quarter-turn pre-rotation must fire and still leave a residual just inside the convergence bound. The bench drives ±pi on each axis, both alone and combined, and also values right at ±pi/2, where the choice to pre-rotate flips. A restart timed in the middle of the second plane, and a `valid_in` held high across the point where `ready` returns, cover the two handshake boundaries that a plain one-shot stimulus never touches.

// File: rtl/eul_rot_pkg.sv
package eul_rot_pkg;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ROT, S_GAIN, S_FIN} seq_state_e;

  // arctan(2^-i) in fixed point with fbits fractional bits
  function automatic int atan_code(input int i, input int fbits);
    real v;
    v = $atan(2.0 ** (-i)) * (2.0 ** fbits);
    return int'(v);
  endfunction

  // sum of all micro-rotation angles: the convergence bound
  function automatic int conv_code(input int iters, input int fbits);
    int s;
    s = 0;
    for (int i = 0; i < iters; i++) s += atan_code(i, fbits);
    return s;
  endfunction

  // inverse CORDIC gain with kbits fractional bits
  function automatic longint gain_code(input int iters, input int kbits);
    real k;
    k = 1.0;
    for (int i = 0; i < iters; i++) k = k / $sqrt(1.0 + 2.0 ** (-2 * i));
    return longint'(k * (2.0 ** kbits));
  endfunction

  function automatic int half_pi_code(input int fbits);
    return int'(1.5707963267948966 * (2.0 ** fbits));
  endfunction

  // first component of the plane: roll (y,z), pitch (z,x), yaw (x,y)
  function automatic logic [1:0] p_sel(input logic [1:0] plane);
    case (plane)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] q_sel(input logic [1:0] plane);
    case (plane)
      2'd0:    return 2'd2;
      2'd1:    return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/eul_seq_ctrl.sv
module eul_seq_ctrl
  import eul_rot_pkg::*;
#(
  parameter int ITER = 14,
  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          valid_in,
  output logic          ready,
  output logic          cap_evt,
  output logic          pre_evt,
  output logic          step_evt,
  output logic          gain_evt,
  output logic          fin_evt,
  output logic [1:0]    plane,
  output logic [IW-1:0] iter
);

  seq_state_e st;

  assign ready    = (st == S_IDLE);
  assign cap_evt  = ready && valid_in && !restart;
  assign pre_evt  = (st == S_PRE)  && !restart;
  assign step_evt = (st == S_ROT)  && !restart;
  assign gain_evt = (st == S_GAIN) && !restart;
  assign fin_evt  = (st == S_FIN)  && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      plane <= 2'd0;
      iter  <= '0;
    end else if (restart) begin
      st    <= S_IDLE;
      plane <= 2'd0;
      iter  <= '0;
    end else begin
      case (st)
        S_IDLE: if (valid_in) begin
          st    <= S_PRE;
          plane <= 2'd0;
        end
        S_PRE: begin
          st   <= S_ROT;
          iter <= '0;
        end
        S_ROT: begin
          if (iter == IW'(ITER - 1)) st <= S_GAIN;
          else iter <= iter + 1'b1;
        end
        S_GAIN: begin
          if (plane == 2'd2) st <= S_FIN;
          else begin
            st    <= S_PRE;
            plane <= plane + 2'd1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eul_rot_datapath.sv
module eul_rot_datapath
  import eul_rot_pkg::*;
#(
  parameter int W     = 14,
  parameter int FRAC  = 10,
  parameter int ITER  = 14,
  parameter int GUARD = 2,
  parameter int DXF   = 4,
  parameter int AXF   = 4,
  parameter int KB    = 16,
  localparam int IW   = (ITER > 1) ? $clog2(ITER) : 1,
  localparam int DW   = W + GUARD + DXF,
  localparam int AW   = W + AXF + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 cap_evt,
  input  logic                 pre_evt,
  input  logic                 step_evt,
  input  logic                 gain_evt,
  input  logic [1:0]           plane,
  input  logic [IW-1:0]        iter,
  input  logic [3*W-1:0]       vec_in,
  input  logic [3*W-1:0]       ang_in,
  output logic [3*W-1:0]       vec_rnd,
  output logic signed [AW-1:0] z_res
);

  localparam logic signed [AW-1:0] HP    = AW'(half_pi_code(FRAC + AXF));
  localparam longint               KQ    = gain_code(ITER, KB);
  localparam logic [KB:0]          KBITS = (KB + 1)'(KQ);
  localparam logic signed [DW:0]   TMAX  = (DW + 1)'((2 ** (W - 1)) - 1);
  localparam logic signed [DW:0]   TMIN  = (DW + 1)'(-(2 ** (W - 1)));

  logic signed [DW-1:0] v   [3];
  logic signed [W-1:0]  ang [3];
  logic signed [AW-1:0] z;
  logic signed [AW-1:0] atan_tab [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_atan
    localparam int ACODE = atan_code(g, FRAC + AXF);
    assign atan_tab[g] = AW'(ACODE);
  end

  // multiply by the inverse CORDIC gain with shifted adds of the constant's bits
  function automatic logic signed [DW-1:0] gain_mul(input logic signed [DW-1:0] x);
    logic signed [DW+KB+1:0] acc;
    acc = '0;
    for (int b = 0; b <= KB; b++)
      if (KBITS[b]) acc = acc + ((DW + KB + 2)'(x) <<< b);
    acc = acc + ((DW + KB + 2)'(1) <<< (KB - 1));
    return DW'(acc >>> KB);
  endfunction

  // drop guard fraction bits with round-half-up, then clamp to W bits
  function automatic logic signed [W-1:0] rnd_sat(input logic signed [DW-1:0] x);
    logic signed [DW:0] t;
    t = (DW + 1)'(x) + (DW + 1)'(2 ** (DXF - 1));
    t = t >>> DXF;
    if (t > TMAX) t = TMAX;
    else if (t < TMIN) t = TMIN;
    return W'(t);
  endfunction

  logic [1:0]           pidx, qidx;
  logic signed [DW-1:0] p_cur, q_cur, p_nxt, q_nxt;
  logic signed [AW-1:0] z_nxt, ang_ext;

  always_comb begin
    pidx    = p_sel(plane);
    qidx    = q_sel(plane);
    p_cur   = v[pidx];
    q_cur   = v[qidx];
    ang_ext = AW'(ang[plane]);
    ang_ext = ang_ext <<< AXF;
    p_nxt   = p_cur;
    q_nxt   = q_cur;
    z_nxt   = z;
    if (pre_evt) begin
      if (ang_ext > HP) begin
        p_nxt = -q_cur;
        q_nxt = p_cur;
        z_nxt = ang_ext - HP;
      end else if (ang_ext < -HP) begin
        p_nxt = q_cur;
        q_nxt = -p_cur;
        z_nxt = ang_ext + HP;
      end else begin
        z_nxt = ang_ext;
      end
    end else if (step_evt) begin
      if (!z[AW-1]) begin
        p_nxt = p_cur - (q_cur >>> iter);
        q_nxt = q_cur + (p_cur >>> iter);
        z_nxt = z - atan_tab[iter];
      end else begin
        p_nxt = p_cur + (q_cur >>> iter);
        q_nxt = q_cur - (p_cur >>> iter);
        z_nxt = z + atan_tab[iter];
      end
    end else if (gain_evt) begin
      p_nxt = gain_mul(p_cur);
      q_nxt = gain_mul(q_cur);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        v[i]   <= '0;
        ang[i] <= '0;
      end
      z <= '0;
    end else if (restart) begin
      for (int i = 0; i < 3; i++) begin
        v[i]   <= '0;
        ang[i] <= '0;
      end
      z <= '0;
    end else if (cap_evt) begin
      for (int i = 0; i < 3; i++) begin
        v[i]   <= DW'($signed(vec_in[i*W +: W])) <<< DXF;
        ang[i] <= $signed(ang_in[i*W +: W]);
      end
      z <= '0;
    end else if (pre_evt || step_evt || gain_evt) begin
      v[pidx] <= p_nxt;
      v[qidx] <= q_nxt;
      z       <= z_nxt;
    end
  end

  always_comb begin
    for (int i = 0; i < 3; i++) vec_rnd[i*W +: W] = rnd_sat(v[i]);
  end

  assign z_res = z;

endmodule

// File: rtl/euler_ned_rotator.sv
module euler_ned_rotator
  import eul_rot_pkg::*;
#(
  parameter int W     = 14,
  parameter int FRAC  = 10,
  parameter int ITER  = 14,
  parameter int GUARD = 2,
  parameter int DXF   = 4,
  parameter int AXF   = 4,
  parameter int KB    = 16,
  localparam int IW   = (ITER > 1) ? $clog2(ITER) : 1,
  localparam int AW   = W + AXF + 1,
  localparam int LAT  = 3 * (ITER + 2) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           valid_in,
  input  logic [3*W-1:0] vec_in,
  input  logic [3*W-1:0] ang_in,
  output logic [3*W-1:0] vec_out,
  output logic           valid_out,
  output logic           ready
);

  logic                 cap_evt, pre_evt, step_evt, gain_evt, fin_evt;
  logic [1:0]           plane;
  logic [IW-1:0]        iter;
  logic [3*W-1:0]       vec_rnd;
  logic signed [AW-1:0] z_res;

  eul_seq_ctrl #(.ITER(ITER)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .valid_in (valid_in),
    .ready    (ready),
    .cap_evt  (cap_evt),
    .pre_evt  (pre_evt),
    .step_evt (step_evt),
    .gain_evt (gain_evt),
    .fin_evt  (fin_evt),
    .plane    (plane),
    .iter     (iter)
  );

  eul_rot_datapath #(
    .W(W), .FRAC(FRAC), .ITER(ITER), .GUARD(GUARD),
    .DXF(DXF), .AXF(AXF), .KB(KB)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .cap_evt  (cap_evt),
    .pre_evt  (pre_evt),
    .step_evt (step_evt),
    .gain_evt (gain_evt),
    .plane    (plane),
    .iter     (iter),
    .vec_in   (vec_in),
    .ang_in   (ang_in),
    .vec_rnd  (vec_rnd),
    .z_res    (z_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out   <= '0;
      valid_out <= 1'b0;
    end else if (restart) begin
      vec_out   <= '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= fin_evt;
      if (fin_evt) vec_out <= vec_rnd;
    end
  end

endmodule

// File: rtl/eul_rot_chk.sv
module eul_rot_chk
  import eul_rot_pkg::*;
#(
  parameter int W    = 14,
  parameter int AW   = 19,
  parameter int LAT  = 49,
  parameter int ITER = 14,
  parameter int FB   = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 restart,
  input logic                 ready,
  input logic                 valid_out,
  input logic [3*W-1:0]       vec_out,
  input logic                 cap_evt,
  input logic                 pre_evt,
  input logic signed [AW-1:0] z_res
);

  localparam logic signed [AW-1:0] CV = AW'(conv_code(ITER, FB));

  logic [15:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (restart) since <= '0;
    else if (cap_evt) since <= 16'd1;
    else if (since != 16'd0 && since < 16'(LAT + 2)) since <= since + 16'd1;
  end

  AST_BUSY_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !ready);  // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ready && !valid_out && vec_out == '0));  // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |=> !valid_out);  // R6

  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_out && !$past(restart)) |-> $stable(vec_out));  // R6

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (since == 16'(LAT + 1) && ready));  // R5

  AST_RESIDUAL_CONVERGES: assert property (@(posedge clk) disable iff (!rst_n)
    pre_evt |=> (z_res <= CV && z_res >= -CV));  // R9

endmodule

bind euler_ned_rotator eul_rot_chk #(
  .W(W), .AW(AW), .LAT(LAT), .ITER(ITER), .FB(FRAC + AXF)
) i_eul_rot_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .ready     (ready),
  .valid_out (valid_out),
  .vec_out   (vec_out),
  .cap_evt   (cap_evt),
  .pre_evt   (pre_evt),
  .z_res     (z_res)
);

// File: tb/test_euler_ned_rotator.sv
module test_euler_ned_rotator;

  localparam int  W    = 14;
  localparam int  FRAC = 10;
  localparam int  ITER = 14;
  localparam int  LAT  = 3 * (ITER + 2) + 1;
  localparam int  TOL  = 6;
  localparam real SC   = 1024.0;
  localparam real PI   = 3.14159265358979;

  logic           clk = 1'b0, rst_n = 1'b0, restart = 1'b0, valid_in = 1'b0;
  logic [3*W-1:0] vec_in = '0, ang_in = '0;
  logic [3*W-1:0] vec_out;
  logic           valid_out, ready;

  euler_ned_rotator i_euler_ned_rotator (
    .clk(clk), .rst_n(rst_n), .restart(restart), .valid_in(valid_in),
    .vec_in(vec_in), .ang_in(ang_in), .vec_out(vec_out),
    .valid_out(valid_out), .ready(ready)
  );

  always #5 clk = ~clk;

  int    checks = 0, failures = 0;
  string cur_req = "R1", exp_req = "R1";
  int    cnt = 0, ex0 = 0, ex1 = 0, ex2 = 0;
  bit    exp_valid = 0, exp_zero = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] enc(input real r);
    int c;
    c = int'(r * SC);
    if (c > 8191) c = 8191;
    if (c < -8192) c = -8192;
    return W'(c);
  endfunction

  function automatic int quant(input real r);
    real s;
    s = r * SC;
    if (s > 8191.0) s = 8191.0;
    if (s < -8192.0) s = -8192.0;
    return int'(s);
  endfunction

  function automatic real fld(input logic [3*W-1:0] b, input int i);
    return real'($signed(b[i*W +: W])) / SC;
  endfunction

  // ideal rotation product: roll in (y,z), pitch in (z,x), yaw in (x,y)
  function automatic void ref_rot(input logic [3*W-1:0] vi, input logic [3*W-1:0] ai,
                                  output int o0, output int o1, output int o2);
    real x, y, z, a, t;
    x = fld(vi, 0); y = fld(vi, 1); z = fld(vi, 2);
    a = fld(ai, 0);
    t = y * $cos(a) - z * $sin(a); z = y * $sin(a) + z * $cos(a); y = t;
    a = fld(ai, 1);
    t = z * $cos(a) - x * $sin(a); x = z * $sin(a) + x * $cos(a); z = t;
    a = fld(ai, 2);
    t = x * $cos(a) - y * $sin(a); y = x * $sin(a) + y * $cos(a); x = t;
    o0 = quant(x); o1 = quant(y); o2 = quant(z);
  endfunction

  // behavioural handshake model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt = 0; exp_valid = 0; exp_zero = 1;
    end else if (restart) begin
      cnt = 0; exp_valid = 0; exp_zero = 1;
    end else if (cnt == 0 && valid_in) begin
      cnt = LAT; exp_valid = 0; exp_req = cur_req;
      ref_rot(vec_in, ang_in, ex0, ex1, ex2);
    end else if (cnt > 0) begin
      cnt--;
      exp_valid = (cnt == 0);
      if (cnt == 0) exp_zero = 0;
    end else begin
      exp_valid = 0;
    end
  end

  // compare against the model on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(ready == (cnt == 0), "R4", "ready", ready, cnt == 0);
      chk(valid_out == exp_valid, "R6", "valid_out", valid_out, exp_valid);
      if (exp_valid) begin
        int a0, a1, a2;
        a0 = $signed(vec_out[0 +: W]);
        a1 = $signed(vec_out[W +: W]);
        a2 = $signed(vec_out[2*W +: W]);
        chk((a0 - ex0) <= TOL && (ex0 - a0) <= TOL, exp_req, "x", a0, ex0);
        chk((a1 - ex1) <= TOL && (ex1 - a1) <= TOL, exp_req, "y", a1, ex1);
        chk((a2 - ex2) <= TOL && (ex2 - a2) <= TOL, exp_req, "z", a2, ex2);
      end
      if (exp_zero) chk(vec_out == '0, "R7", "cleared vec_out", vec_out, 0);
    end
  end

  task automatic send(input real x, input real y, input real z,
                      input real ph, input real th, input real ps,
                      input string req, input bit noisy);
    int seen;
    seen = 0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    cur_req  = req;
    vec_in   = {enc(z), enc(y), enc(x)};
    ang_in   = {enc(ps), enc(th), enc(ph)};
    valid_in = 1'b1;
    for (int k = 1; k <= LAT + 4; k++) begin
      @(negedge clk);
      if (k == 1 && !noisy) valid_in = 1'b0;
      if (k == 1 && noisy) begin
        vec_in = ~vec_in;
        ang_in = {enc(0.3), enc(-0.2), enc(1.0)};
      end
      if (k == 20) valid_in = 1'b0;
      if (valid_out && seen == 0) seen = k;
    end
    chk(seen == LAT + 1, "R5", "latency", seen, LAT + 1);
  endtask

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R10", "ready after reset", ready, 1);
    chk(valid_out == 1'b0, "R10", "valid_out after reset", valid_out, 0);
    chk(vec_out == '0, "R10", "vec_out after reset", vec_out, 0);

    // R3: data moving with valid_in low is never taken
    for (int k = 0; k < 10; k++) begin
      vec_in = {enc(1.0 + k), enc(-0.5), enc(2.0)};
      @(negedge clk);
      chk(ready == 1'b1 && valid_out == 1'b0, "R3", "idle without valid_in",
          {ready, valid_out}, 2);
    end

    send(1.5, -2.25, 3.0, 0.0, 0.0, 0.0, "R2", 0);
    send(-0.75, 4.5, -1.0, 0.0, 0.0, 0.0, "R2", 0);
    send(2.0, 1.0, -1.0, 0.5, 0.0, 0.0, "R1", 0);
    send(1.0, 2.0, 0.5, 0.0, -1.0, 0.0, "R1", 0);
    send(-3.0, 1.0, 2.0, 0.0, 0.0, 1.2, "R1", 0);
    send(1.0, -2.0, 3.0, 0.7, -0.4, 2.5, "R1", 0);
    send(-2.5, 0.75, -1.25, -2.1, 1.3, -0.9, "R1", 0);
    send(1.0, 2.0, 3.0, PI, 0.0, 0.0, "R9", 0);
    send(1.0, 2.0, 3.0, 0.0, -PI, 0.0, "R9", 0);
    send(0.5, -1.0, 2.0, -PI, PI, PI, "R9", 0);
    send(1.0, 1.0, 1.0, PI / 2.0, -PI / 2.0, PI / 2.0, "R9", 0);
    send(7.9, 7.9, 0.0, 0.0, 0.0, PI / 4.0, "R8", 0);
    send(-7.9, -7.9, 0.0, 0.0, 0.0, PI / 4.0, "R8", 0);
    send(2.0, -1.5, 0.25, 0.9, 0.6, -1.7, "R4", 1);

    // R7: abort in the middle of the second plane
    @(negedge clk);
    while (!ready) @(negedge clk);
    cur_req  = "R7";
    vec_in   = {enc(1.0), enc(2.0), enc(3.0)};
    ang_in   = {enc(0.4), enc(0.4), enc(0.4)};
    valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    repeat (20) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(ready == 1'b1, "R7", "ready after restart", ready, 1);
    chk(vec_out == '0, "R7", "vec_out after restart", vec_out, 0);
    pulses = 0;
    repeat (LAT + 5) begin
      @(negedge clk);
      if (valid_out) pulses++;
    end
    chk(pulses == 0, "R7", "aborted result pulses", pulses, 0);

    // R7: restart beats a simultaneous valid_in
    restart  = 1'b1;
    valid_in = 1'b1;
    @(negedge clk);
    restart  = 1'b0;
    valid_in = 1'b0;
    chk(ready == 1'b1, "R7", "no capture under restart", ready, 1);

    // R5/R6: valid_in held high is taken again as soon as ready returns
    cur_req  = "R6";
    vec_in   = {enc(-1.0), enc(0.5), enc(2.5)};
    ang_in   = {enc(-0.3), enc(1.1), enc(0.2)};
    valid_in = 1'b1;
    pulses   = 0;
    for (int k = 1; k <= 2 * LAT + 8; k++) begin
      @(negedge clk);
      if (k == LAT + 2) valid_in = 1'b0;
      if (valid_out) pulses++;
    end
    chk(pulses == 2, "R5", "back-to-back results", pulses, 2);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule